// File: doc/BRIEF.md
# Clock-Controlled Cascade Keystream Generator

This block produces a keystream one bit per step. It is built from a chain of stages, and every stage holds an array of shift registers. Even-numbered stages hold linear-feedback shift registers. Odd-numbered stages hold feedback-with-carry shift registers, each with a small integer memory. Every stage merges the low bits of its registers into one combined bit. That bit gates whether the next stage's registers advance on the current step, and it picks the merging rule the next stage uses. The combined bit of the last stage is the keystream bit.

A stage merges its bits in one of two ways. The first is addition with carry: the stage adds its register bits to a stored carry, emits the low bit of the sum and keeps the rest of the sum as the new carry. The second is parity combined with the incoming gate bit. A linear stage that advances uses addition with carry, and so does a carry-feedback stage that is held. In the other two cases the stage uses parity. Stage 0 advances on every step.

A single seed word initialises every register. The seed is rotated by the register's global index, XORed with that index, and replaced by 1 when the result is zero. The load also clears every carry and every memory. Reset gives the same state as a load with seed zero. The number of stages, the registers per stage, the register widths and the feedback tap masks are all parameters.

Top module: `cascade_keystream_gen`

## Requirements
- R1: Synchronous reset drives `ks_valid_o` and `ks_bit_o` to 0. It leaves the generator in exactly the state that a load of seed 0 produces, so the keystream that follows is identical to the one after such a load.
- R2: While `load_i` is high, the register with global index k = stage*REGS_PER_STAGE + position is loaded with the low bits of (seed rotated left by k mod SEED_W) XOR k. A zero result is replaced by 1. All carries and memories are cleared. `ks_valid_o` is 0 in the next cycle, and load takes priority over `enable_i`.
- R3: A cycle with `enable_i` high and `load_i` low is one step. In the next cycle `ks_valid_o` is 1 and `ks_bit_o` holds the final stage's combined bit for that step.
- R4: Stage 0 (linear registers) advances on every step. Its combined bit is bit 0 of (sum of its register output bits + its carry), and its carry becomes that sum shifted right by one.
- R5: An odd (carry-feedback) stage whose incoming bit is 1 advances, and its combined bit is the inverted parity of its register output bits. When the incoming bit is 0, the stage holds its registers and combines by addition with carry, as in R4, updating its carry.
- R6: An even stage after stage 0 whose incoming bit is 1 advances and combines by addition with carry. When the incoming bit is 0, the stage holds its registers and its carry, and its combined bit is the parity of its held output bits.
- R7: A linear register shifts right and outputs bit 0. Its new top bit is the parity of (state AND LFSR_TAPS). The default mask 0x002D taps bits 0, 2, 3 and 5.
- R8: A carry-feedback register forms t = memory + popcount(state AND FCSR_TAPS), shifts right with bit 0 of t entering the top, and stores t shifted right by one as its memory. The default mask 0x8029 taps bits 0, 3, 5 and 15.
- R9: A cycle with `enable_i` and `load_i` both low changes no register. `ks_valid_o` is 0 in the next cycle, `ks_bit_o` keeps its value, and the stream continues later exactly as if the idle cycle had not occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load all registers from the seed word |
| seed_i | input | SEED_W | Seed word, SEED_W = max(LFSR_W, FCSR_W) |
| enable_i | input | 1 | Advance the generator by one step |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is new this cycle |

## Verification
The hardest case to reach from the ports is a seed whose derived value is exactly zero for one register. The zero-replacement path is only taken then. The bench builds seed 0x6000: rotated by 3 it becomes 0x0003, and XORed with index 3 it is zero, so stage 0 position 3 must receive 1. The bench compares the following stream against its own model. Carries and memories that are non-zero when a reload arrives are reached by loading table entries back to back in the middle of long streams. Idle cycles are inserted at several spacings to show that held state resumes cleanly.

// File: rtl/cascade_pkg.sv
package cascade_pkg;

    typedef enum logic {
        KIND_LFSR = 1'b0,
        KIND_FCSR = 1'b1
    } reg_kind_e;

    // Seed spreading: rotate the seed within 'width' bits by 'idx', then mix in idx.
    function automatic logic [63:0] seed_word(input logic [63:0] seed,
                                              input int unsigned width,
                                              input int unsigned idx);
        logic [63:0] rot;
        rot = '0;
        for (int unsigned b = 0; b < 64; b++) begin
            if (b < width) rot[(b + idx) % width] = seed[b];
        end
        return rot ^ 64'(idx);
    endfunction

endpackage

// File: rtl/cc_lfsr_cell.sv
module cc_lfsr_cell
#(
    parameter int W        = 16,
    parameter int SEED_W   = 16,
    parameter int SEED_IDX = 0,
    parameter logic [W-1:0] TAPS = W'(1)
)(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              adv_i,
    output logic              out_o
);
    import cascade_pkg::*;

    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_state_t;

    lfsr_state_t cur_q, nxt_d;
    logic [63:0] wide_seed;
    logic [W-1:0] init_word;

    always_comb begin
        wide_seed = seed_word(rst_i ? 64'd0 : 64'(seed_i), SEED_W, SEED_IDX);
        init_word = (wide_seed[W-1:0] == '0) ? W'(1) : wide_seed[W-1:0];

        nxt_d = cur_q;
        if (rst_i || load_i) begin
            nxt_d.sr = init_word;
        end else if (adv_i) begin
            nxt_d.sr = {^(cur_q.sr & TAPS), cur_q.sr[W-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign out_o = cur_q.sr[0];

endmodule

// File: rtl/cc_fcsr_cell.sv
module cc_fcsr_cell
#(
    parameter int W        = 16,
    parameter int SEED_W   = 16,
    parameter int SEED_IDX = 0,
    parameter logic [W-1:0] TAPS = W'(1),
    localparam int MEM_W   = $clog2(W + 1),
    localparam int SUM_W   = MEM_W + 1
)(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              adv_i,
    output logic              out_o
);
    import cascade_pkg::*;

    typedef struct packed {
        logic [W-1:0]     sr;
        logic [MEM_W-1:0] mem;
    } fcsr_state_t;

    fcsr_state_t cur_q, nxt_d;
    logic [63:0] wide_seed;
    logic [W-1:0] init_word;
    logic [SUM_W-1:0] tally;

    always_comb begin
        wide_seed = seed_word(rst_i ? 64'd0 : 64'(seed_i), SEED_W, SEED_IDX);
        init_word = (wide_seed[W-1:0] == '0) ? W'(1) : wide_seed[W-1:0];

        tally = SUM_W'(cur_q.mem);
        for (int b = 0; b < W; b++) begin
            tally = tally + SUM_W'(cur_q.sr[b] & TAPS[b]);
        end

        nxt_d = cur_q;
        if (rst_i || load_i) begin
            nxt_d.sr  = init_word;
            nxt_d.mem = '0;
        end else if (adv_i) begin
            nxt_d.sr  = {tally[0], cur_q.sr[W-1:1]};
            nxt_d.mem = tally[SUM_W-1:1];
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

    assign out_o = cur_q.sr[0];

endmodule

// File: rtl/cc_stage.sv
module cc_stage
    import cascade_pkg::*;
#(
    parameter reg_kind_e KIND = KIND_LFSR,
    parameter int STAGE_IDX   = 0,
    parameter int M           = 5,
    parameter int LFSR_W      = 16,
    parameter int FCSR_W      = 16,
    parameter int SEED_W      = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = LFSR_W'(1),
    parameter logic [FCSR_W-1:0] FCSR_TAPS = FCSR_W'(1),
    localparam int AW         = $clog2(2 * M) + 1,
    localparam int CW         = AW - 1
)(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              adv_i,
    input  logic              pred_i,
    output logic              bit_o
);

    typedef struct packed {
        logic [CW-1:0] carry;
    } stage_state_t;

    stage_state_t cur_q, nxt_d;
    logic [M-1:0] cell_out;
    logic         adv_cells;
    logic         use_carry;
    logic [AW-1:0] acc;

    assign adv_cells = adv_i & pred_i;

    generate
        for (genvar r = 0; r < M; r++) begin : g_cell
            if (KIND == KIND_LFSR) begin : g_lfsr
                cc_lfsr_cell #(
                    .W        (LFSR_W),
                    .SEED_W   (SEED_W),
                    .SEED_IDX (STAGE_IDX * M + r),
                    .TAPS     (LFSR_TAPS)
                ) u_cell (
                    .clk_i  (clk_i),
                    .rst_i  (rst_i),
                    .load_i (load_i),
                    .seed_i (seed_i),
                    .adv_i  (adv_cells),
                    .out_o  (cell_out[r])
                );
            end else begin : g_fcsr
                cc_fcsr_cell #(
                    .W        (FCSR_W),
                    .SEED_W   (SEED_W),
                    .SEED_IDX (STAGE_IDX * M + r),
                    .TAPS     (FCSR_TAPS)
                ) u_cell (
                    .clk_i  (clk_i),
                    .rst_i  (rst_i),
                    .load_i (load_i),
                    .seed_i (seed_i),
                    .adv_i  (adv_cells),
                    .out_o  (cell_out[r])
                );
            end
        end
    endgenerate

    always_comb begin
        // Linear stages add when gated on; carry-feedback stages add when gated off.
        use_carry = ((KIND == KIND_LFSR) == pred_i);

        acc = AW'(cur_q.carry);
        for (int r = 0; r < M; r++) begin
            acc = acc + AW'(cell_out[r]);
        end

        bit_o = use_carry ? acc[0] : ((^cell_out) ^ pred_i);

        nxt_d = cur_q;
        if (rst_i || load_i) begin
            nxt_d.carry = '0;
        end else if (adv_i && use_carry) begin
            nxt_d.carry = acc[AW-1:1];
        end
    end

    always_ff @(posedge clk_i) begin
        cur_q <= nxt_d;
    end

endmodule

// File: rtl/cascade_keystream_gen.sv
module cascade_keystream_gen
    import cascade_pkg::*;
#(
    parameter int N_STAGES       = 10,
    parameter int REGS_PER_STAGE = 5,
    parameter int LFSR_W         = 16,
    parameter int FCSR_W         = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = LFSR_W'('h002D),
    parameter logic [FCSR_W-1:0] FCSR_TAPS = FCSR_W'('h8029),
    localparam int SEED_W        = (LFSR_W > FCSR_W) ? LFSR_W : FCSR_W
)(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    input  logic              enable_i,
    output logic              ks_bit_o,
    output logic              ks_valid_o
);

    typedef struct packed {
        logic ks_bit;
        logic ks_valid;
    } out_state_t;

    out_state_t out_q, out_d;
    logic [N_STAGES-1:0] stage_bits;
    logic                step;

    assign step = enable_i & ~load_i;

    generate
        for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
            localparam reg_kind_e KIND_S = ((s % 2) == 0) ? KIND_LFSR : KIND_FCSR;
            logic pred;
            if (s == 0) begin : g_head
                assign pred = 1'b1;
            end else begin : g_link
                assign pred = stage_bits[s-1];
            end

            cc_stage #(
                .KIND      (KIND_S),
                .STAGE_IDX (s),
                .M         (REGS_PER_STAGE),
                .LFSR_W    (LFSR_W),
                .FCSR_W    (FCSR_W),
                .SEED_W    (SEED_W),
                .LFSR_TAPS (LFSR_TAPS),
                .FCSR_TAPS (FCSR_TAPS)
            ) u_stage (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .load_i (load_i),
                .seed_i (seed_i),
                .adv_i  (step),
                .pred_i (pred),
                .bit_o  (stage_bits[s])
            );
        end
    endgenerate

    always_comb begin
        out_d = out_q;
        if (rst_i) begin
            out_d.ks_bit   = 1'b0;
            out_d.ks_valid = 1'b0;
        end else if (step) begin
            out_d.ks_bit   = stage_bits[N_STAGES-1];
            out_d.ks_valid = 1'b1;
        end else begin
            out_d.ks_valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign ks_bit_o   = out_q.ks_bit;
    assign ks_valid_o = out_q.ks_valid;

endmodule

// File: rtl/cascade_keystream_chk.sv
module cascade_keystream_chk #(
    parameter int N_STAGES = 10
)(
    input logic                clk_i,
    input logic                rst_i,
    input logic                load_i,
    input logic                enable_i,
    input logic [N_STAGES-1:0] stage_bits,
    input logic                ks_bit_o,
    input logic                ks_valid_o
);

    AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (enable_i && !load_i) |=> ks_valid_o);                 // R3

    AST_LOAD_NO_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> !ks_valid_o);                                // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enable_i && !load_i) |=> !ks_valid_o);                // R9

    AST_IDLE_HOLDS_CHAIN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enable_i && !load_i) |=> $stable(stage_bits));        // R9

    AST_IDLE_HOLDS_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
        (!enable_i && !load_i) |=> $stable(ks_bit_o));          // R9

    AST_LOAD_HOLDS_BIT: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> $stable(ks_bit_o));                          // R2

endmodule

bind cascade_keystream_gen cascade_keystream_chk #(
    .N_STAGES (N_STAGES)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .load_i     (load_i),
    .enable_i   (enable_i),
    .stage_bits (stage_bits),
    .ks_bit_o   (ks_bit_o),
    .ks_valid_o (ks_valid_o)
);

// File: tb/tb_cascade_keystream_gen.sv
`timescale 1ns/1ps
module tb_cascade_keystream_gen;

    localparam int N  = 10;
    localparam int M  = 5;
    localparam int W  = 16;
    localparam logic [15:0] LT = 16'h002D;
    localparam logic [15:0] FT = 16'h8029;

    typedef struct packed {
        logic [15:0] seed;
        logic [7:0]  steps;
        logic [3:0]  idle_every;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'hACE1, 8'd40, 4'd0},
        '{16'h0001, 8'd30, 4'd3},
        '{16'hFFFF, 8'd30, 4'd0},
        '{16'h6000, 8'd30, 4'd0},   // k=3 word is zero before replacement
        '{16'h1234, 8'd25, 4'd4},
        '{16'h8000, 8'd30, 4'd2}
    };

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic load_i = 1'b0;
    logic [15:0] seed_i = '0;
    logic enable_i = 1'b0;
    logic ks_bit_o, ks_valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cascade_keystream_gen #(
        .N_STAGES(N), .REGS_PER_STAGE(M), .LFSR_W(W), .FCSR_W(W),
        .LFSR_TAPS(LT), .FCSR_TAPS(FT)
    ) dut (
        .clk_i(clk), .rst_i(rst_i), .load_i(load_i), .seed_i(seed_i),
        .enable_i(enable_i), .ks_bit_o(ks_bit_o), .ks_valid_o(ks_valid_o)
    );

    // Behavioural model built from the requirements
    logic [15:0] m_sr  [N][M];
    int          m_mem [N][M];
    int          m_carry [N];

    task automatic model_load(input logic [15:0] sd);
        for (int s = 0; s < N; s++) begin
            for (int r = 0; r < M; r++) begin
                int k, sh, v;
                k  = s * M + r;
                sh = k % W;
                v  = ((int'(sd) << sh) | (int'(sd) >> (W - sh))) & 'hFFFF;
                v  = v ^ k;
                if (v == 0) v = 1;
                m_sr[s][r]  = v[15:0];
                m_mem[s][r] = 0;
            end
            m_carry[s] = 0;
        end
    endtask

    function automatic logic model_step();
        logic pred;
        pred = 1'b1;
        for (int s = 0; s < N; s++) begin
            int pc; logic par, b, is_lin;
            pc = 0; par = 1'b0;
            for (int r = 0; r < M; r++) begin
                pc  += int'(m_sr[s][r][0]);
                par ^= m_sr[s][r][0];
            end
            is_lin = ((s % 2) == 0);
            if (is_lin == pred) begin
                int sum;
                sum = pc + m_carry[s];
                b = sum[0];
                m_carry[s] = sum >> 1;
            end else begin
                b = par ^ pred;
            end
            if (pred) begin
                for (int r = 0; r < M; r++) begin
                    if (is_lin) begin
                        m_sr[s][r] = {^(m_sr[s][r] & LT), m_sr[s][r][15:1]};
                    end else begin
                        int t;
                        t = m_mem[s][r] + $countones(m_sr[s][r] & FT);
                        m_sr[s][r]  = {t[0], m_sr[s][r][15:1]};
                        m_mem[s][r] = t >> 1;
                    end
                end
            end
            pred = b;
        end
        return pred;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_step(input string req);
        logic exp;
        @(negedge clk);
        load_i = 1'b0; enable_i = 1'b1;
        exp = model_step();
        @(posedge clk); #1;
        check({req, " valid"}, ks_valid_o, 1'b1);   // R3
        check({req, " bit"},   ks_bit_o,   exp);
    endtask

    task automatic do_idle();
        logic held;
        @(negedge clk);
        held = ks_bit_o;
        load_i = 1'b0; enable_i = 1'b0;
        @(posedge clk); #1;
        check("R9 idle valid", ks_valid_o, 1'b0);
        check("R9 idle bit held", ks_bit_o, held);
    endtask

    task automatic do_load(input logic [15:0] sd, input logic en);
        @(negedge clk);
        load_i = 1'b1; seed_i = sd; enable_i = en;
        @(posedge clk); #1;
        check("R2 no valid after load", ks_valid_o, 1'b0);
        model_load(sd);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", ks_valid_o, 1'b0);
        check("R1 reset bit",   ks_bit_o,   1'b0);
        @(negedge clk);
        rst_i = 1'b0;
        model_load(16'h0000);
        for (int i = 0; i < 40; i++) do_step("R1/R4/R5/R6/R7/R8 stream after reset");

        // Table walk: load, stream, optional idle cycles between steps
        for (int v = 0; v < 6; v++) begin
            do_load(VEC[v].seed, 1'b0);
            for (int i = 0; i < int'(VEC[v].steps); i++) begin
                do_step("R2/R3/R4/R5/R6/R7/R8 table stream");
                if (VEC[v].idle_every != 0 && (i % int'(VEC[v].idle_every)) == 0)
                    do_idle();   // R9 resume after idle
            end
        end

        // R2: load wins over enable in the same cycle
        do_load(16'h5A5A, 1'b1);
        for (int i = 0; i < 20; i++) do_step("R2 stream after load with enable");

        // R2: zero-replacement seed again, right after a busy stream
        do_load(16'h6000, 1'b0);
        for (int i = 0; i < 20; i++) do_step("R2 zero-replaced register stream");

        // R1: reset in mid-stream restores the seed-zero state
        @(negedge clk);
        rst_i = 1'b1; enable_i = 1'b1;
        @(posedge clk); #1;
        check("R1 mid-stream reset valid", ks_valid_o, 1'b0);
        check("R1 mid-stream reset bit",   ks_bit_o,   1'b0);
        @(negedge clk);
        rst_i = 1'b0; enable_i = 1'b0;
        model_load(16'h0000);
        for (int i = 0; i < 20; i++) do_step("R1 stream after mid-stream reset");

        @(negedge clk);
        enable_i = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule